// File: doc/BRIEF.md
# DRAM Burst Column Order Sequencer

This block produces the column order of a single eight-slot DRAM burst, one beat per clock. A controller pulses `start` together with the low three bits of the starting column, a wrap-type select, a chop select, a flag that says whether the chop length is fixed by the mode register, and a read/write flag. During the following eight clocks the block presents a registered beat index and per-beat flags. These flags say whether the beat is driven, whether it is a high-impedance read slot, or whether it is a don't-care write slot.

Read bursts wrap inside the four-column half that holds the start column. Sequential type rotates the low two bits. Interleaved type XORs the start column with the beat number. Write bursts ignore the low start bits. A four-beat chop drives only the first four slots. Besides the end-of-burst pulse, the block issues a write-completion pulse for write-recovery counters. This pulse comes two slots earlier when the chop length is fixed by mode. A start that overlaps a running burst is dropped and flagged. A start on the final slot chains a new burst with no gap.

Top module: `bco_burst_seq`

## Requirements
- R1: With `wrap_il`=0, a read of 8 beats presents, for beat k (0..7), the column whose bit 2 is start bit 2 XOR k bit 2 and whose bits 1:0 are (start bits 1:0 + k) mod 4. Example: start 5 gives 5,6,7,4,1,2,3,0.
- R2: With `wrap_il`=1, a read of 8 beats presents start XOR k on beat k. Example: start 5 gives 5,4,7,6,1,0,3,2.
- R3: A write of 8 beats presents 0,1,...,7 whatever the start column and wrap type.
- R4: A chopped read (`chop`=1) presents the R1/R2 order on beats 0..3. On beats 4..7 it drives `beat_hiz`=1, `beat_valid`=0 and `beat_col`=0.
- R5: A chopped write presents {start bit 2, k[1:0]} on beats 0..3, so the result is 0..3 or 4..7. On beats 4..7 it drives `beat_dc`=1, `beat_valid`=0 and `beat_col`=0.
- R6: Beat 0 appears in the cycle after the clock edge that samples an accepted `start`. Beat k appears k cycles later. `busy` is high for exactly those eight cycles.
- R7: `burst_done` is high only during beat slot 7.
- R8: On a write, `wr_done` pulses for one cycle. The pulse comes on slot 5 when `chop`=1 and `chop_fixed`=1, and on slot 7 otherwise. It never pulses on a read.
- R9: A `start` sampled while beat slots 0..6 are showing is ignored: the running burst carries on unchanged. `start_err` is high for the following cycle.
- R10: A `start` sampled while slot 7 is showing is accepted. Beat 0 of the new burst follows in the next cycle.
- R11: While `rst_n` is low at a clock edge, all outputs are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Burst request strobe |
| start_col | input | 3 | Low bits of the starting column |
| wrap_il | input | 1 | Wrap type: 0 sequential, 1 interleaved |
| chop | input | 1 | 1 = four-beat chop, 0 = eight beats |
| chop_fixed | input | 1 | 1 = chop length set by mode, not per command |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| beat_col | output | 3 | Column index of the current beat |
| beat_valid | output | 1 | Beat is driven with data |
| beat_hiz | output | 1 | Chopped read slot, outputs high-impedance |
| beat_dc | output | 1 | Chopped write slot, data ignored |
| busy | output | 1 | A beat slot is being presented |
| burst_done | output | 1 | Final beat slot |
| wr_done | output | 1 | Internal write completion pulse |
| start_err | output | 1 | A start was dropped during a burst |

## Verification
The hardest case to reach is the boundary between a start that is dropped and one that is chained. Both depend on which slot is showing when the strobe is sampled. The bench raises `start` at a chosen slot of a running burst. It then checks that `start_err` rises and that the old order continues unchanged. The next strobe is timed on slot 7, and the bench checks that beat 0 of the new burst follows without an idle cycle. Every mix of start column, wrap type, chop, chop source and direction is swept in full.

// File: rtl/bco_pkg.sv
// Package: shared sizes and record types of the burst column order sequencer.
// Assumes an eight-slot burst whose chop keeps half the slots.
package bco_pkg;
    localparam int BCO_BL     = 8;
    localparam int COL_W      = $clog2(BCO_BL);
    localparam int LO_W       = COL_W - 1;
    localparam int CHOP_BL    = BCO_BL / 2;
    localparam int WR_EARLY   = 2;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             il;
        logic             chop;
        logic             fixed;
        logic             wr;
    } burst_cfg_t;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             valid;
        logic             hiz;
        logic             dc;
        logic             done;
        logic             wdone;
        logic             busy;
    } beat_out_t;
endpackage

// File: rtl/bco_slot_ctrl.sv
// Slot controller: accepts start strobes, holds the burst settings and
// counts beat slots. It exposes next-state values so that the output stage
// can register the beat that matches them.
// Assumes a start on the last slot may chain a new burst.
module bco_slot_ctrl
    import bco_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  burst_cfg_t       cfg_in,
    output burst_cfg_t       cfg_d,
    output logic [COL_W-1:0] cnt_d,
    output logic             active_d,
    output logic             collide
);
    localparam logic [COL_W-1:0] LAST = COL_W'(BCO_BL - 1);

    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] cnt_q;
    logic             active_q;
    logic             accept;
    logic             last_q;

    // Purpose: decide acceptance and compute the next slot state.
    always_comb begin
        last_q   = active_q && (cnt_q == LAST);
        accept   = start && (!active_q || last_q);
        collide  = start && active_q && !last_q;
        cfg_d    = cfg_q;
        cnt_d    = cnt_q;
        active_d = active_q;
        if (accept) begin
            cfg_d    = cfg_in;
            cnt_d    = '0;
            active_d = 1'b1;
        end else if (active_q) begin
            if (last_q) begin
                active_d = 1'b0;
                cnt_d    = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Purpose: hold slot state across clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            cfg_q    <= cfg_d;
            cnt_q    <= cnt_d;
            active_q <= active_d;
        end
    end
endmodule

// File: rtl/bco_order_calc.sv
// Order calculator: purely combinational mapping from burst settings and
// slot number to the beat column and the slot flags.
// Assumes chop masking applies to the upper half of the slots.
module bco_order_calc
    import bco_pkg::*;
(
    input  burst_cfg_t       cfg,
    input  logic [COL_W-1:0] slot,
    input  logic             active,
    output beat_out_t        beat
);
    localparam logic [COL_W-1:0] LAST  = COL_W'(BCO_BL - 1);
    localparam logic [COL_W-1:0] EARLY = COL_W'(BCO_BL - 1 - WR_EARLY);

    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] il_col;
    logic [COL_W-1:0] wr_col;
    logic [COL_W-1:0] pick;
    logic [LO_W-1:0]  lo_sum;
    logic             masked;
    logic [COL_W-1:0] wr_slot;

    // Purpose: build the candidate orders for each burst kind.
    always_comb begin
        lo_sum  = cfg.col[LO_W-1:0] + slot[LO_W-1:0];
        seq_col = {cfg.col[COL_W-1] ^ slot[COL_W-1], lo_sum};
        il_col  = cfg.col ^ slot;
        wr_col  = cfg.chop ? {cfg.col[COL_W-1], slot[LO_W-1:0]} : slot;
    end

    // Purpose: select the order and derive the slot flags.
    always_comb begin
        beat    = '0;
        masked  = cfg.chop && slot[COL_W-1];
        wr_slot = (cfg.chop && cfg.fixed) ? EARLY : LAST;
        if (cfg.wr)      pick = wr_col;
        else if (cfg.il) pick = il_col;
        else             pick = seq_col;
        if (active) begin
            beat.busy  = 1'b1;
            beat.col   = masked ? '0 : pick;
            beat.valid = !masked;
            beat.hiz   = masked && !cfg.wr;
            beat.dc    = masked && cfg.wr;
            beat.done  = (slot == LAST);
            beat.wdone = cfg.wr && (slot == wr_slot);
        end
    end
endmodule

// File: rtl/bco_out_stage.sv
// Output stage: registers the beat record and the collision flag so that
// every port of the sequencer comes straight from a flop.
module bco_out_stage
    import bco_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  beat_out_t beat_d,
    input  logic      err_d,
    output beat_out_t beat_q,
    output logic      err_q
);
    // Purpose: register outputs with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            beat_q <= beat_d;
            err_q  <= err_d;
        end
    end
endmodule

// File: rtl/bco_burst_seq.sv
// Top of the burst column order sequencer: joins slot control, order
// calculation and the registered output stage.
// Assumes inputs are synchronous to clk.
module bco_burst_seq
    import bco_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             wrap_il,
    input  logic             chop,
    input  logic             chop_fixed,
    input  logic             is_write,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_valid,
    output logic             beat_hiz,
    output logic             beat_dc,
    output logic             busy,
    output logic             burst_done,
    output logic             wr_done,
    output logic             start_err
);
    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_d;
    logic [COL_W-1:0] cnt_d;
    logic             active_d;
    logic             collide;
    beat_out_t        beat_d;
    beat_out_t        beat_q;

    // Purpose: pack the command fields into one record.
    always_comb begin
        cfg_in.col   = start_col;
        cfg_in.il    = wrap_il;
        cfg_in.chop  = chop;
        cfg_in.fixed = chop_fixed;
        cfg_in.wr    = is_write;
    end

    bco_slot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_in   (cfg_in),
        .cfg_d    (cfg_d),
        .cnt_d    (cnt_d),
        .active_d (active_d),
        .collide  (collide)
    );

    bco_order_calc u_calc (
        .cfg    (cfg_d),
        .slot   (cnt_d),
        .active (active_d),
        .beat   (beat_d)
    );

    bco_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_d (beat_d),
        .err_d  (collide),
        .beat_q (beat_q),
        .err_q  (start_err)
    );

    // Purpose: unpack the registered record onto the ports.
    always_comb begin
        beat_col   = beat_q.col;
        beat_valid = beat_q.valid;
        beat_hiz   = beat_q.hiz;
        beat_dc    = beat_q.dc;
        busy       = beat_q.busy;
        burst_done = beat_q.done;
        wr_done    = beat_q.wdone;
    end
endmodule

// File: rtl/bco_burst_seq_chk.sv
// Checker for the burst column order sequencer, bound to every instance.
module bco_burst_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic beat_valid,
    input logic beat_hiz,
    input logic beat_dc,
    input logic busy,
    input logic burst_done,
    input logic wr_done,
    input logic start_err
);
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beat_valid, beat_hiz, beat_dc}));

    a_r7_done_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> busy);

    a_r8_wdone_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> busy);

    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> ($past(start) && $past(busy) && !$past(burst_done)));

    a_r10_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (start && burst_done) |=> (busy && !start_err));

    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!busy && !beat_valid && !start_err));
endmodule

bind bco_burst_seq bco_burst_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .beat_valid (beat_valid),
    .beat_hiz   (beat_hiz),
    .beat_dc    (beat_dc),
    .busy       (busy),
    .burst_done (burst_done),
    .wr_done    (wr_done),
    .start_err  (start_err)
);

// File: tb/bco_burst_seq_bench.sv
`timescale 1ns/1ps
module bco_burst_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] start_col = '0;
    logic       wrap_il = 1'b0;
    logic       chop = 1'b0;
    logic       chop_fixed = 1'b0;
    logic       is_write = 1'b0;
    logic [2:0] beat_col;
    logic       beat_valid, beat_hiz, beat_dc, busy, burst_done, wr_done, start_err;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bco_burst_seq u_bco_burst_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .wrap_il(wrap_il), .chop(chop), .chop_fixed(chop_fixed), .is_write(is_write),
        .beat_col(beat_col), .beat_valid(beat_valid), .beat_hiz(beat_hiz),
        .beat_dc(beat_dc), .busy(busy), .burst_done(burst_done),
        .wr_done(wr_done), .start_err(start_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected column of beat k, from the requirements.
    function automatic int exp_col(int col, int il, int ch, int wr, int k);
        int half_base, rot;
        if (ch != 0 && k >= 4) return 0;
        if (wr != 0) begin
            if (ch != 0) return ((col >= 4) ? 4 : 0) + k;
            return k;
        end
        if (il != 0) return col ^ k;
        half_base = (col / 4) * 4;
        rot = ((col % 4) + (k % 4)) % 4;
        if (k < 4) return half_base + rot;
        return (4 - half_base) + rot;
    endfunction

    task automatic check_beat(int col, int il, int ch, int fx, int wr, int k);
        int masked = (ch != 0 && k >= 4) ? 1 : 0;
        int wslot = (ch != 0 && fx != 0) ? 5 : 7;
        string tag;
        if (wr != 0) tag = (ch != 0) ? "R5" : "R3";
        else if (ch != 0) tag = "R4";
        else tag = (il != 0) ? "R2" : "R1";
        check({tag, " col"}, beat_col, exp_col(col, il, ch, wr, k));
        check({tag, " valid"}, beat_valid, 1 - masked);
        check("R4 hiz", beat_hiz, (masked != 0 && wr == 0) ? 1 : 0);
        check("R5 dc", beat_dc, (masked != 0 && wr != 0) ? 1 : 0);
        check("R6 busy", busy, 1);
        check("R7 done", burst_done, (k == 7) ? 1 : 0);
        check("R8 wr_done", wr_done, (wr != 0 && k == wslot) ? 1 : 0);
    endtask

    task automatic drive_cfg(int col, int il, int ch, int fx, int wr);
        start_col = 3'(col); wrap_il = il[0]; chop = ch[0];
        chop_fixed = fx[0]; is_write = wr[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", busy, 0);
        check("R11 valid", beat_valid, 0);
        check("R11 col", beat_col, 0);
        check("R11 err", start_err, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle busy", busy, 0);

        // Exhaustive sweep of all command settings
        for (int wr = 0; wr < 2; wr++)
            for (int ch = 0; ch < 2; ch++)
                for (int fx = 0; fx < 2; fx++)
                    for (int il = 0; il < 2; il++)
                        for (int col = 0; col < 8; col++) begin
                            drive_cfg(col, il, ch, fx, wr);
                            start = 1'b1;
                            @(negedge clk);
                            start = 1'b0;
                            for (int k = 0; k < 8; k++) begin
                                if (k > 0) @(negedge clk);
                                check_beat(col, il, ch, fx, wr, k);
                            end
                            @(negedge clk);
                            check("R6 busy ends", busy, 0);
                            check("R6 valid ends", beat_valid, 0);
                        end

        // R9 and R10: collision mid-burst, then gapless chaining on slot 7
        drive_cfg(2, 0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            check_beat(2, 0, 0, 0, 0, k);
            if (k == 4) check("R9 err raised", start_err, 1);
            else check("R9 err quiet", start_err, 0);
            if (k == 3) begin
                drive_cfg(7, 1, 1, 1, 1);
                start = 1'b1;
            end else if (k == 7) begin
                drive_cfg(5, 1, 0, 0, 0);
                start = 1'b1;
            end else begin
                start = 1'b0;
                drive_cfg(2, 0, 0, 0, 0);
            end
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 0) begin
                start = 1'b0;
                check("R10 no err on chain", start_err, 0);
            end
            check_beat(5, 1, 0, 0, 0, k);
        end
        @(negedge clk);
        check("R10 chain ends", busy, 0);

        // R11: reset in the middle of a burst
        drive_cfg(1, 0, 0, 0, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid-burst busy", busy, 0);
        check("R11 mid-burst col", beat_col, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 stays idle", busy, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule